// File: doc/BRIEF.md
# Configurable Multi-Term Multiply-Accumulate Sum

This combinational block produces one output word `y` as the wrapped sum of a list of terms plus a group of one-bit increments. Each term is either a product of two operands or a single operand passed through. A term is added or subtracted, and it is treated as signed or unsigned. All term operands arrive packed side by side in one input bus. The one-bit increments arrive on a second bus.

The term list is fixed at elaboration by one packed bit-serial parameter, `CFG`, of length `CFG_LEN`. The parameter sets the number of terms, the width of every operand, and each term's signedness and subtract mode. Generate loops decode the parameter into one term unit per record. The term outputs and the count of set increment bits are then summed modulo 2^`Y_W`.

The block is used wherever a netlist holds a fixed sum of products, for example a dot product, a filter tap sum or an adder tree fed by carry bits.

Top module: `amac_sum`

## Requirements
- R1: `CFG` bits [3:0], least significant bit first, hold the size-field width N (0 to 15). Each term record after them is 2+2N bits long. The record holds, in this order: a signed flag (1 = signed), a subtract flag (1 = subtract), the size of operand a (N bits, LSB first) and the size of operand b (N bits, LSB first).
- R2: Operands are sliced from `a_bus` in ascending bit order starting at bit 0, in the order a of term 0, b of term 0, a of term 1, b of term 1, and so on.
- R3: `CFG_LEN` must equal 4 plus the combined length of all term records, and the operand sizes must add up to `A_W`. Any other parameter set stops elaboration.
- R4: A term whose operand b has size zero contributes operand a alone, extended to `Y_W` bits.
- R5: A term whose operand b has nonzero size contributes the product a*b, formed at `Y_W` bits.
- R6: When a term's signed flag is 1, both of its operands are sign-extended. When the flag is 0, both are zero-extended. An operand of size zero has the value zero.
- R7: A term with its subtract flag at 1 is subtracted from the running sum. Otherwise it is added.
- R8: Every bit of `bit_bus` adds 1 (unsigned) to the sum. When `B_W` is 0, the port is one bit wide and that bit has no effect on `y`.
- R9: The sum starts at zero, and `y` is the exact total reduced modulo 2^`Y_W`.
- R10: A term record with both sizes zero contributes nothing, whatever its flags are. With `a_bus` all zero, `y` equals the number of set bits in `bit_bus`, modulo 2^`Y_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_bus | input | A_W | Packed term operands, lowest term first |
| bit_bus | input | max(B_W,1) | One-bit unsigned addends |
| y | output | Y_W | Wrapped sum of all terms and addends |

## Verification
Three parameter sets are tried. The first mixes signed and unsigned products, pass-through terms and a record with both sizes zero. The second has wide 16x16 products on a 12-bit result with no addend bits. The third has one-bit operands and twenty addend bits on a 4-bit result. Directed operand patterns each light one term alone. A negative signed operand against its unsigned bit pattern separates sign extension from zero extension, a lone subtract term exposes an inverted subtract flag, and a nonzero bit placed at a single slice boundary reveals an off-by-one offset. Random operands and addend bits, compared with an independent decoder of the same parameter, then cover carries, wrap-around and interaction between terms.

// File: rtl/amac_pkg.sv
package amac_pkg;

  localparam int CFG_MAX = 512;
  localparam int HDR_W   = 4;

  function automatic int size_bits(logic [CFG_MAX-1:0] cfg);
    return int'(cfg[HDR_W-1:0]);
  endfunction

  function automatic int rec_len(logic [CFG_MAX-1:0] cfg);
    return 2 + 2 * size_bits(cfg);
  endfunction

  function automatic int term_count(logic [CFG_MAX-1:0] cfg, int len);
    return (len - HDR_W) / rec_len(cfg);
  endfunction

  function automatic int rec_base(logic [CFG_MAX-1:0] cfg, int k);
    return HDR_W + k * rec_len(cfg);
  endfunction

  function automatic int read_field(logic [CFG_MAX-1:0] cfg, int pos, int n);
    int v;
    v = 0;
    for (int i = 0; i < n; i++)
      if (cfg[pos+i]) v = v | (1 << i);
    return v;
  endfunction

  function automatic bit term_signed(logic [CFG_MAX-1:0] cfg, int k);
    return cfg[rec_base(cfg, k)];
  endfunction

  function automatic bit term_sub(logic [CFG_MAX-1:0] cfg, int k);
    return cfg[rec_base(cfg, k) + 1];
  endfunction

  function automatic int size_a(logic [CFG_MAX-1:0] cfg, int k);
    return read_field(cfg, rec_base(cfg, k) + 2, size_bits(cfg));
  endfunction

  function automatic int size_b(logic [CFG_MAX-1:0] cfg, int k);
    return read_field(cfg, rec_base(cfg, k) + 2 + size_bits(cfg), size_bits(cfg));
  endfunction

  // bit offset of operand a of term k inside the operand bus
  function automatic int offset_a(logic [CFG_MAX-1:0] cfg, int k);
    int off;
    off = 0;
    for (int j = 0; j < k; j++)
      off = off + size_a(cfg, j) + size_b(cfg, j);
    return off;
  endfunction

endpackage

// File: rtl/amac_term.sv
module amac_term #(
  parameter int A_W   = 8,
  parameter int Y_W   = 8,
  parameter int OFF_A = 0,
  parameter int SA    = 4,
  parameter int OFF_B = 4,
  parameter int SB    = 4,
  parameter bit SGN   = 1'b0,
  parameter bit SUB   = 1'b0
) (
  input  logic [A_W-1:0] a_bus,
  output logic [Y_W-1:0] term_o
);

  logic [Y_W-1:0] ext_a;
  logic [Y_W-1:0] ext_b;
  logic [Y_W-1:0] mag;
  logic           unused_bits;

  assign unused_bits = ^a_bus;

  if (SA > 0) begin : g_opa
    logic [SA-1:0] raw_a;
    assign raw_a = a_bus[OFF_A +: SA];
    if (SGN) begin : g_sx
      assign ext_a = Y_W'(signed'(raw_a));
    end else begin : g_zx
      assign ext_a = Y_W'(raw_a);
    end
  end else begin : g_opa_none
    assign ext_a = '0;
  end

  if (SB > 0) begin : g_opb
    logic [SB-1:0] raw_b;
    assign raw_b = a_bus[OFF_B +: SB];
    if (SGN) begin : g_sx
      assign ext_b = Y_W'(signed'(raw_b));
    end else begin : g_zx
      assign ext_b = Y_W'(raw_b);
    end
    assign mag = ext_a * ext_b;
  end else begin : g_pass
    assign ext_b = '0;
    assign mag   = ext_a;
  end

  if (SUB) begin : g_neg
    assign term_o = '0 - mag;
  end else begin : g_pos
    assign term_o = mag;
  end

endmodule

// File: rtl/amac_bitsum.sv
module amac_bitsum #(
  parameter int B_W = 3,
  parameter int Y_W = 8,
  localparam int BP_W = (B_W > 0) ? B_W : 1
) (
  input  logic [BP_W-1:0] bit_bus,
  output logic [Y_W-1:0]  cnt_o
);

  if (B_W > 0) begin : g_count
    always_comb begin
      cnt_o = '0;
      for (int i = 0; i < B_W; i++)
        cnt_o = cnt_o + Y_W'(bit_bus[i]);
    end
  end else begin : g_none
    logic unused_bit;
    assign unused_bit = bit_bus[0];
    assign cnt_o      = '0;
  end

endmodule

// File: rtl/amac_sum.sv
module amac_sum #(
  parameter int A_W     = 38,
  parameter int B_W     = 3,
  parameter int Y_W     = 16,
  parameter int CFG_LEN = 54,
  parameter logic [CFG_LEN-1:0] CFG = {
    {4'd0, 4'd7, 1'b1, 1'b1},
    {4'd0, 4'd0, 1'b1, 1'b1},
    {4'd6, 4'd4, 1'b0, 1'b0},
    {4'd0, 4'd5, 1'b1, 1'b0},
    {4'd8, 4'd8, 1'b0, 1'b1},
    4'd4
  },
  localparam int BP_W = (B_W > 0) ? B_W : 1
) (
  input  logic [A_W-1:0]  a_bus,
  input  logic [BP_W-1:0] bit_bus,
  output logic [Y_W-1:0]  y
);

  localparam int CM = amac_pkg::CFG_MAX;
  localparam logic [CM-1:0] CFG_X = CM'(CFG);
  localparam int N_SZ  = amac_pkg::size_bits(CFG_X);
  localparam int RL    = amac_pkg::rec_len(CFG_X);
  localparam int NT    = amac_pkg::term_count(CFG_X, CFG_LEN);
  localparam int NT_P  = (NT > 0) ? NT : 1;
  localparam int A_TOT = amac_pkg::offset_a(CFG_X, NT);

  // R3: parameter consistency is enforced at elaboration
  if (CFG_LEN > CM || CFG_LEN < amac_pkg::HDR_W) begin : g_bad_len
    $error("amac_sum: CFG_LEN %0d outside supported range", CFG_LEN);
  end
  if ((CFG_LEN - amac_pkg::HDR_W) % RL != 0) begin : g_bad_rec
    $error("amac_sum: CFG_LEN %0d not header plus whole records of %0d bits", CFG_LEN, RL);
  end
  if (A_TOT != A_W) begin : g_bad_a
    $error("amac_sum: operand sizes total %0d, bus is %0d (N=%0d)", A_TOT, A_W, N_SZ);
  end

  logic [NT_P*Y_W-1:0] term_flat;
  logic [Y_W-1:0]      bit_cnt;
  logic [Y_W-1:0]      acc;

  for (genvar k = 0; k < NT; k++) begin : g_term
    localparam int SA  = amac_pkg::size_a(CFG_X, k);
    localparam int SB  = amac_pkg::size_b(CFG_X, k);
    localparam int OFA = amac_pkg::offset_a(CFG_X, k);
    if (SA == 0 && SB == 0) begin : g_skip
      assign term_flat[k*Y_W +: Y_W] = '0;
    end else begin : g_live
      amac_term #(
        .A_W  (A_W),
        .Y_W  (Y_W),
        .OFF_A(OFA),
        .SA   (SA),
        .OFF_B(OFA + SA),
        .SB   (SB),
        .SGN  (amac_pkg::term_signed(CFG_X, k)),
        .SUB  (amac_pkg::term_sub(CFG_X, k))
      ) u_term (
        .a_bus (a_bus),
        .term_o(term_flat[k*Y_W +: Y_W])
      );
    end
  end

  if (NT == 0) begin : g_no_terms
    logic unused_a;
    assign unused_a  = ^a_bus;
    assign term_flat = '0;
  end

  amac_bitsum #(
    .B_W(B_W),
    .Y_W(Y_W)
  ) u_bits (
    .bit_bus(bit_bus),
    .cnt_o  (bit_cnt)
  );

  always_comb begin
    acc = bit_cnt;
    for (int k = 0; k < NT; k++)
      acc = acc + term_flat[k*Y_W +: Y_W];
  end

  assign y = acc;

endmodule

// File: rtl/amac_sum_chk.sv
module amac_sum_chk #(
  parameter int A_W  = 8,
  parameter int B_W  = 1,
  parameter int Y_W  = 8,
  parameter int NT_P = 1,
  localparam int BP_W = (B_W > 0) ? B_W : 1
) (
  input logic [A_W-1:0]      a_bus,
  input logic [BP_W-1:0]     bit_bus,
  input logic [Y_W-1:0]      y,
  input logic [NT_P*Y_W-1:0] term_flat,
  input logic [Y_W-1:0]      bit_cnt
);

  logic [Y_W-1:0] ones;
  logic [Y_W-1:0] term_total;

  always_comb begin
    ones = (B_W > 0) ? Y_W'($countones(bit_bus)) : '0;
    term_total = '0;
    for (int k = 0; k < NT_P; k++)
      term_total = term_total + term_flat[k*Y_W +: Y_W];
  end

  always_comb begin
    // R8
    bit_count_chk: assert (bit_cnt == ones)
      else $error("bit count %0d, set bits %0d", bit_cnt, ones);
    // R9
    acc_sum_chk: assert (y == term_total + ones)
      else $error("y %0h differs from term total plus bits", y);
    // R10
    terms_idle_chk: assert (a_bus != '0 || term_flat == '0)
      else $error("term nonzero with all operands zero");
    // R10
    idle_out_chk: assert (a_bus != '0 || y == ones)
      else $error("y %0h with zero operands, expected %0h", y, ones);
  end

endmodule

bind amac_sum amac_sum_chk #(
  .A_W (A_W),
  .B_W (B_W),
  .Y_W (Y_W),
  .NT_P(NT_P)
) u_chk (
  .a_bus    (a_bus),
  .bit_bus  (bit_bus),
  .y        (y),
  .term_flat(term_flat),
  .bit_cnt  (bit_cnt)
);

// File: tb/test_amac_sum.sv
module test_amac_sum;

  // configuration 0: mixed terms (matches the block defaults)
  localparam int A0 = 38, B0 = 3, Y0 = 16, L0 = 54;
  localparam logic [L0-1:0] CFG0 = {
    {4'd0, 4'd7, 1'b1, 1'b1},
    {4'd0, 4'd0, 1'b1, 1'b1},
    {4'd6, 4'd4, 1'b0, 1'b0},
    {4'd0, 4'd5, 1'b1, 1'b0},
    {4'd8, 4'd8, 1'b0, 1'b1},
    4'd4
  };
  // configuration 1: wide products, narrow result, no addend bits
  localparam int A1 = 64, B1 = 0, Y1 = 12, L1 = 28;
  localparam logic [L1-1:0] CFG1 = {
    {5'd16, 5'd16, 1'b0, 1'b0},
    {5'd16, 5'd16, 1'b1, 1'b1},
    4'd5
  };
  // configuration 2: one-bit operands, many addend bits
  localparam int A2 = 5, B2 = 20, Y2 = 4, L2 = 16;
  localparam logic [L2-1:0] CFG2 = {
    {1'b1, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b1, 1'b0, 1'b1},
    {1'b1, 1'b1, 1'b0, 1'b1},
    4'd1
  };

  logic clk;
  logic rst_n;
  int   checks;
  int   errors;
  bit   done;

  logic [A0-1:0] a0;  logic [B0-1:0] b0;  logic [Y0-1:0] y0;
  logic [A1-1:0] a1;  logic [0:0]    b1;  logic [Y1-1:0] y1;
  logic [A2-1:0] a2;  logic [B2-1:0] b2;  logic [Y2-1:0] y2;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  amac_sum #(.A_W(A0), .B_W(B0), .Y_W(Y0), .CFG_LEN(L0), .CFG(CFG0))
    i_amac_sum (.a_bus(a0), .bit_bus(b0), .y(y0));
  amac_sum #(.A_W(A1), .B_W(B1), .Y_W(Y1), .CFG_LEN(L1), .CFG(CFG1))
    i_amac_sum_w (.a_bus(a1), .bit_bus(b1), .y(y1));
  amac_sum #(.A_W(A2), .B_W(B2), .Y_W(Y2), .CFG_LEN(L2), .CFG(CFG2))
    i_amac_sum_n (.a_bus(a2), .bit_bus(b2), .y(y2));

  function automatic longint get_op(logic [255:0] a, int pos, int sz, bit sg);
    longint v;
    v = 0;
    for (int i = 0; i < sz; i++)
      if (a[pos+i]) v = v | (longint'(1) << i);
    if (sg && sz > 0 && a[pos+sz-1]) v = v - (longint'(1) << sz);
    return v;
  endfunction

  // independent reference decoder and evaluator
  function automatic longint ref_y(logic [255:0] cfg, int clen, logic [255:0] a,
                                   logic [63:0] b, int bw, int yw);
    int     n, rl, nt, pos, sa, sb;
    bit     sg, sub;
    longint acc, va, vb, t;
    n   = int'(cfg[3:0]);
    rl  = 2 + 2 * n;
    nt  = (clen - 4) / rl;
    pos = 0;
    acc = 0;
    for (int k = 0; k < nt; k++) begin
      sg  = cfg[4 + k*rl];
      sub = cfg[5 + k*rl];
      sa  = 0;
      sb  = 0;
      for (int i = 0; i < n; i++) begin
        if (cfg[6 + k*rl + i])     sa = sa | (1 << i);
        if (cfg[6 + k*rl + n + i]) sb = sb | (1 << i);
      end
      va  = get_op(a, pos, sa, sg); pos = pos + sa;
      vb  = get_op(a, pos, sb, sg); pos = pos + sb;
      if (sa == 0 && sb == 0) continue;
      t   = (sb == 0) ? va : va * vb;
      acc = sub ? acc - t : acc + t;
    end
    for (int i = 0; i < bw; i++)
      acc = acc + longint'(b[i]);
    return acc & ((longint'(1) << yw) - 1);
  endfunction

  task automatic check(longint got, longint exp, string req);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic run0(logic [A0-1:0] a, logic [B0-1:0] b, string req);
    @(negedge clk);
    a0 = a; b0 = b;
    #5;
    check(longint'(y0), ref_y(256'(CFG0), L0, 256'(a), 64'(b), B0, Y0), req);
  endtask

  task automatic run1(logic [A1-1:0] a, logic b, string req);
    @(negedge clk);
    a1 = a; b1 = b;
    #5;
    check(longint'(y1), ref_y(256'(CFG1), L1, 256'(a), 64'(0), 0, Y1), req);
  endtask

  task automatic run2(logic [A2-1:0] a, logic [B2-1:0] b, string req);
    @(negedge clk);
    a2 = a; b2 = b;
    #5;
    check(longint'(y2), ref_y(256'(CFG2), L2, 256'(a), 64'(b), B2, Y2), req);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    a0 = '0; b0 = '0; a1 = '0; b1 = '0; a2 = '0; b2 = '0;
    rst_n = 1'b0;
    void'($urandom(32'd20140906));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R10: quiet inputs give zero, skipped record has no effect
    @(negedge clk); #5;
    check(longint'(y0), 0, "R10 idle y0");
    check(longint'(y1), 0, "R10 idle y1");
    check(longint'(y2), 0, "R10 idle y2");
    // R8: bit addends only
    run0('0, 3'b111, "R8 three bits");
    check(longint'(y0), 3, "R8 literal count");
    run2('0, 20'hFFFFF, "R8 R9 twenty bits wrap");
    check(longint'(y2), 4, "R9 literal wrap of 20");
    // R8: zero-width addend bus ignores its port bit
    run1('0, 1'b1, "R8 B_W zero");
    check(longint'(y1), 0, "R8 B_W zero literal");
    // R5 R6: signed product -1 * 2
    run0(38'h00000002FF, '0, "R5 R6 signed product");
    check(longint'(y0), 16'hFFFE, "R6 literal -2");
    // R4 R7: unsigned pass-through subtract of 31
    run0(38'(5'h1F) << 16, '0, "R4 R7 unsigned pass sub");
    check(longint'(y0), 16'hFFE1, "R7 literal -31");
    // R4 R6 R7: signed pass-through subtract of -64
    run0(38'(7'h40) << 31, '0, "R4 R6 signed pass sub");
    check(longint'(y0), 16'h0040, "R6 literal +64");
    // R5 R6: unsigned product 15 * 63
    run0((38'(4'hF) << 21) | (38'(6'h3F) << 25), '0, "R5 R6 unsigned product");
    check(longint'(y0), 945, "R5 literal 945");
    // R2: single bits at slice boundaries
    for (int i = 0; i < A0; i++) run0(38'(1) << i, '0, "R2 boundary bit y0");
    for (int i = 0; i < A2; i++) run2(5'(1) << i, '0, "R2 boundary bit y2");
    // R9: largest operands on the narrow result
    run1({16'hFFFF, 16'hFFFF, 16'h8000, 16'h8000}, 1'b0, "R9 wrap wide");
    run1({16'h0000, 16'h0000, 16'h7FFF, 16'h8000}, 1'b0, "R6 R7 signed sub");
    // R1 R3: random operands over all three parameter sets
    for (int i = 0; i < 300; i++)
      run0(38'({$urandom, $urandom}), 3'($urandom), "R1 R3 random y0");
    for (int i = 0; i < 300; i++)
      run1({$urandom, $urandom}, 1'($urandom), "R1 R9 random y1");
    for (int i = 0; i < 300; i++)
      run2(5'($urandom), 20'($urandom), "R1 R6 random y2");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule